// File: doc/BRIEF.md
# Five-Tap Gaussian Smoothing Sequencer

This block computes one smoothed point of a stored signed 8-bit waveform. A requester places a centre index on `idx` and raises `req`. The sequencer captures the index. It then fetches the centre sample and its two neighbours on each side from an internal 256-entry synchronous ROM, one fetch per cycle. Each sample is weighted by a fixed symmetric integer kernel through one shared signed multiplier. The weighted terms are summed into an 8-bit register that wraps on overflow.

When the sum is complete the block raises `done` and holds `result` steady for as long as `req` stays high. Dropping `req` releases the block back to idle, and a new request can be accepted on the next cycle. The intended use is as a hardware reference that checks a software-driven processor computing the same equation. It has eight named states:

- IDLE: waits for `req`.
- LOAD: the index is held and the accumulator cleared.
- TAP0 through TAP4: one multiply-accumulate per cycle.
- HOLD: result presented.

The transitions are:

- IDLE→LOAD when `req` is sampled high.
- LOAD→TAP0→TAP1→TAP2→TAP3→TAP4→HOLD, one step per clock, unconditionally.
- HOLD→HOLD while `req` is high.
- HOLD→IDLE when `req` is sampled low.

Top module: `gauss5_seq`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `result` is 0.
- R2: In IDLE with `req` low, `done` stays 0 and `result` keeps its last value whatever `idx` does.
- R3: The result for centre index i is the sum over taps k=0..4 of T(W[i-2+k], C[k]). The coefficients C, in tap order from offset -2 to +2, are 17, 29, 35, 29, 17.
- R4: Each term T(w,c) is bits 15..8 of the 16-bit signed product w*c, which equals the product shifted right by 8 with rounding toward minus infinity.
- R5: The five terms are added in 8 bits, and any carry beyond bit 7 is discarded.
- R6: `done` becomes 1 after the seventh rising clock edge, counting the edge at which `req` is first sampled high in IDLE.
- R7: The index is captured at the starting edge only. Changes on `idx` afterwards, including during HOLD, do not affect `result`. While `req` stays high in HOLD, `done` stays 1 and `result` is unchanged.
- R8: When `req` is sampled low in HOLD, `done` is 0 after that edge. A request raised on the following cycle starts a new computation.
- R9: For indices 0, 1, 254 and 255, neighbour addresses wrap modulo 256, and no error is signalled.
- R10: ROM word a, read as signed 8-bit, is W[a] = ((37*a) mod 256) XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Level request; high starts, low releases |
| idx | input | 8 | Centre sample index, captured at start |
| result | output | 8 | Smoothed sample, signed two's complement |
| done | output | 1 | High while the result is presented in HOLD |

## Verification
The result of a request is due exactly seven rising edges after the edge that first samples `req` high. The bench raises `req` half a cycle before an edge, counts falling edges until `done` appears, and requires the count to be seven before it compares `result`. The release is due one edge after `req` is sampled low, so the bench checks `done` at the next falling edge. Hold and idle stability are checked over several falling edges while `idx` is deliberately changed. Every one of the 256 indices is requested back to back, and the expected values are computed from the ROM formula and the kernel.

// File: rtl/gauss5_pkg.sv
package gauss5_pkg;

    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int TAPS = 5;
    localparam int TW   = $clog2(TAPS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_TAP0, ST_TAP1, ST_TAP2, ST_TAP3, ST_TAP4, ST_HOLD
    } seq_state_t;

    // Symmetric kernel, scaled by 128 and rounded.
    function automatic logic signed [DW-1:0] kernel_coef(input logic [TW-1:0] k);
        case (k)
            3'd0, 3'd4: kernel_coef = 8'sd17;
            3'd1, 3'd3: kernel_coef = 8'sd29;
            3'd2:       kernel_coef = 8'sd35;
            default:    kernel_coef = '0;
        endcase
    endfunction

    // Address offset of tap k relative to the centre: k - 2.
    function automatic logic [AW-1:0] tap_offset(input logic [TW-1:0] k);
        tap_offset = AW'(k) - AW'(TAPS / 2);
    endfunction

    // Computed waveform contents.
    function automatic logic [DW-1:0] wave_word(input logic [AW-1:0] a);
        logic [DW-1:0] p;
        p = DW'(a) * DW'(37);
        wave_word = p ^ DW'(8'h5A);
    endfunction

endpackage

// File: rtl/gauss5_rom.sv
module gauss5_rom
    import gauss5_pkg::*;
#(
    parameter int A_W = AW,
    parameter int D_W = DW
) (
    input  logic           clk,
    input  logic [A_W-1:0] addr,
    output logic [D_W-1:0] data
);

    // Synchronous read, one cycle of latency.
    always_ff @(posedge clk) begin
        data <= D_W'(wave_word(AW'(addr)));
    end

endmodule

// File: rtl/gauss5_mac.sv
module gauss5_mac #(
    parameter int D_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic signed [D_W-1:0] sample,
    input  logic signed [D_W-1:0] coef,
    output logic        [D_W-1:0] acc
);

    localparam int PW = 2 * D_W;

    logic signed [PW-1:0] prod;

    // The single shared multiplier.
    always_comb begin
        prod = sample * coef;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            // Keep the high half of the product and wrap the sum.
            acc <= acc + prod[PW-1:D_W];
        end
    end

endmodule

// File: rtl/gauss5_ctrl.sv
module gauss5_ctrl
    import gauss5_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] rom_addr,
    output logic [TW-1:0] tap_sel,
    output logic          acc_clr,
    output logic          acc_en,
    output logic          done
);

    seq_state_t    state, state_nx;
    logic [AW-1:0] base_q;
    logic [TW-1:0] issue_sel;

    // State register and index capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req) begin
                base_q <= idx;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) state_nx = ST_LOAD;
            ST_LOAD: state_nx = ST_TAP0;
            ST_TAP0: state_nx = ST_TAP1;
            ST_TAP1: state_nx = ST_TAP2;
            ST_TAP2: state_nx = ST_TAP3;
            ST_TAP3: state_nx = ST_TAP4;
            ST_TAP4: state_nx = ST_HOLD;
            ST_HOLD: if (!req) state_nx = ST_IDLE;
        endcase
    end

    // Outputs. The ROM address runs one tap ahead of the multiply.
    always_comb begin
        issue_sel = '0;
        tap_sel   = '0;
        acc_clr   = 1'b0;
        acc_en    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOAD: begin acc_clr = 1'b1; issue_sel = 3'd0; end
            ST_TAP0: begin acc_en = 1'b1; tap_sel = 3'd0; issue_sel = 3'd1; end
            ST_TAP1: begin acc_en = 1'b1; tap_sel = 3'd1; issue_sel = 3'd2; end
            ST_TAP2: begin acc_en = 1'b1; tap_sel = 3'd2; issue_sel = 3'd3; end
            ST_TAP3: begin acc_en = 1'b1; tap_sel = 3'd3; issue_sel = 3'd4; end
            ST_TAP4: begin acc_en = 1'b1; tap_sel = 3'd4; end
            ST_HOLD: done = 1'b1;
        endcase
        rom_addr = base_q + tap_offset(issue_sel);
    end

endmodule

// File: rtl/gauss5_seq.sv
module gauss5_seq
    import gauss5_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [7:0]   idx,
    output logic [7:0]   result,
    output logic         done
);

    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic [TW-1:0] tap_sel;
    logic          acc_clr;
    logic          acc_en;

    gauss5_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .idx      (idx),
        .rom_addr (rom_addr),
        .tap_sel  (tap_sel),
        .acc_clr  (acc_clr),
        .acc_en   (acc_en),
        .done     (done)
    );

    gauss5_rom #(.A_W(AW), .D_W(DW)) u_rom (
        .clk  (clk),
        .addr (rom_addr),
        .data (rom_data)
    );

    gauss5_mac #(.D_W(DW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .en     (acc_en),
        .sample (rom_data),
        .coef   (kernel_coef(tap_sel)),
        .acc    (result)
    );

endmodule

// File: rtl/gauss5_seq_chk.sv
module gauss5_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [7:0] result,
    input logic       done
);

    // R1: reset state
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!done && result == 8'd0));

    // R6: done appears seven edges after the starting edge
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(req, 7));

    // R7: stable result while the request is held
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> (done && $stable(result)));

    // R8: release one edge after req is low
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> !done);

endmodule

bind gauss5_seq gauss5_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .result (result),
    .done   (done)
);

// File: tb/gauss5_seq_test.sv
`timescale 1ns/1ps
module gauss5_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       req = 1'b0;
    logic [7:0] idx = 8'd0;
    logic [7:0] result;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gauss5_seq uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .idx    (idx),
        .result (result),
        .done   (done)
    );

    // R10: waveform formula, signed
    function automatic int wave(input int a);
        int v;
        v = ((37 * (a & 255)) & 255) ^ 32'h5A;
        return (v > 127) ? v - 256 : v;
    endfunction

    // R3, R4, R5 reference model
    function automatic int model(input int i);
        int c[5] = '{17, 29, 35, 29, 17};
        int s = 0;
        for (int k = 0; k < 5; k++) begin
            int p = wave(i - 2 + k) * c[k];
            s += (p >>> 8);
        end
        return s & 255;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        idx = 8'hC3;
        @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle done", int'(done), 0);
        chk("R2 idle result", int'(result), 0);

        for (int i = 0; i < 256; i++) begin
            int cyc;
            int held;
            string tag;
            tag = (i >= 2 && i <= 253) ? "R3 R4 R5 R10 result" : "R9 wrapped result";
            idx = 8'(i);
            req = 1'b1;
            cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
                if (cyc == 1 && (i % 3 == 0)) idx = ~8'(i);   // R7 late idx change
            end while (!done && cyc < 40);
            chk("R6 latency", cyc, 7);
            chk(tag, int'(result), model(i));
            held = int'(result);
            for (int h = 0; h < 3; h++) begin
                idx = idx + 8'd91;
                @(negedge clk);
                chk("R7 hold done", int'(done), 1);
                chk("R7 hold result", int'(result), held);
            end
            req = 1'b0;
            @(negedge clk);
            chk("R8 release", int'(done), 0);
            if (i % 16 == 0) begin
                for (int h = 0; h < 2; h++) begin
                    idx = idx ^ 8'h5C;
                    @(negedge clk);
                    chk("R2 idle done", int'(done), 0);
                    chk("R2 idle result", int'(result), held);
                end
            end
        end
        finish_run();
    end

endmodule